// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the control sequencer in front of a successive-approximation converter. Software programs it through one control word, using a write port and a read port. The word carries an enable, a start bit, a sticky completion flag, a three-bit clock-divider select and a channel select. When a conversion starts, the block takes a copy of the channel select and sends it for one cycle on a trigger output, which an external sample-and-hold uses. The block then times the conversion in divided converter clocks and raises a completion interrupt when it ends.

The converter clock period is a power of two of the system clock: 2 to the power of the divider select, and a select of zero is handled as one. A normal conversion lasts 13 converter clocks. The first conversion after the block is switched on lasts 25 converter clocks, which covers the analog settling time. Software cannot withdraw a start request. It ends only when the conversion completes or when the block is switched off.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Writing 0 to the start bit (bit 1) never clears it. Once set, it reads 1 until the conversion completes or the block is disabled.
- R2: A write that sets the start bit while it reads 0, with the enable bit (bit 0) of that same write at 1, starts a conversion. In the cycle after the write, `trig_valid` is high for exactly one cycle and `trig_chan` holds the channel field (bits CHAN_W+5:6) of that write.
- R3: A start request written with the enable bit at 0 has no effect. The start bit reads 0, no trigger pulse appears, and the flag does not change.
- R4: The converter clock period is 2^s system clocks, where s is the divider select (bits 5:3), and s = 0 gives the same period as s = 1 (2 cycles).
- R5: The first conversion after a write that takes enable from 0 to 1 ends exactly FIRST_LEN×2^s clock edges after the start edge.
- R6: Every later conversion ends exactly NORMAL_LEN×2^s clock edges after its start edge.
- R7: At completion the start bit clears, the flag (bit 2) sets, `irq` goes high, and the next conversion is a normal-length one.
- R8: A write with enable at 0 during a conversion aborts it. The start bit clears and the flag is not set, then or later.
- R9: The flag is sticky. A write with bit 2 at 1 clears it, and a write with bit 2 at 0 leaves it unchanged.
- R10: Changing the divider select or the channel select during a conversion affects neither the length of that conversion nor `trig_chan`.
- R11: After reset, `rd_data` reads 0 and `irq` and `trig_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | CHAN_W+6 | Control word to write |
| rd_data | output | CHAN_W+6 | Current control word |
| trig_valid | output | 1 | One-cycle pulse when a conversion starts |
| trig_chan | output | CHAN_W | Channel captured at the last start |
| irq | output | 1 | Completion interrupt (the sticky flag) |

## Verification
The bench uses the default parameters: a 4-bit channel select and lengths of 25 and 13 converter clocks. With these values, every divider select from 0 to 7 finishes within a few thousand cycles. The bench therefore covers the shared zero/one period, a long divide of 128 and both conversion lengths. The small channel field lets the bench compare every captured channel value on every cycle against a behavioural model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int PSC_W    = 3;
    localparam int B_EN     = 0;
    localparam int B_GO     = 1;
    localparam int B_FLAG   = 2;
    localparam int PSC_LSB  = 3;
    localparam int CHAN_LSB = PSC_LSB + PSC_W;
    localparam int DIV_W    = (1 << PSC_W) - 1;

    // divider select to shift amount: zero behaves as one
    function automatic logic [PSC_W-1:0] eff_shift(input logic [PSC_W-1:0] sel);
        return (sel == '0) ? PSC_W'(1) : sel;
    endfunction
endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [PSC_W-1:0] sel,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] last;

    always_comb begin
        last  = (DIV_W'(1) << eff_shift(sel)) - DIV_W'(1);
        tick  = run && !restart && (cnt_q == last);
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = tick ? '0 : cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int FIRST_LEN  = 25,
    parameter int NORMAL_LEN = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic tick,
    input  logic long_sel,
    output logic done
);
    localparam int MAX_LEN = (FIRST_LEN > NORMAL_LEN) ? FIRST_LEN : NORMAL_LEN;
    localparam int CW      = $clog2(MAX_LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last;

    always_comb begin
        last  = long_sel ? CW'(FIRST_LEN - 1) : CW'(NORMAL_LEN - 1);
        done  = run && !restart && tick && (cnt_q == last);
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (run && tick) begin
            cnt_d = done ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W     = 4,
    parameter int FIRST_LEN  = 25,
    parameter int NORMAL_LEN = 13
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [CHAN_LSB+CHAN_W-1:0] wr_data,
    output logic [CHAN_LSB+CHAN_W-1:0] rd_data,
    output logic                       trig_valid,
    output logic [CHAN_W-1:0]          trig_chan,
    output logic                       irq
);
    typedef struct packed {
        logic              en;
        logic              go;
        logic              first;
        logic              flag;
        logic              long_sel;
        logic              trig_vld;
        logic [PSC_W-1:0]  psc;
        logic [PSC_W-1:0]  div;
        logic [CHAN_W-1:0] chan;
        logic [CHAN_W-1:0] trig_ch;
    } state_t;

    state_t st_d, st_q;
    logic   launch, abort, tick, conv_done, timer_done;
    logic   en_new, first_new;

    adc_seq_clkdiv u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (launch || abort),
        .run     (st_q.go),
        .sel     (st_q.div),
        .tick    (tick)
    );

    adc_seq_timer #(
        .FIRST_LEN  (FIRST_LEN),
        .NORMAL_LEN (NORMAL_LEN)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (launch || abort),
        .run      (st_q.go),
        .tick     (tick),
        .long_sel (st_q.long_sel),
        .done     (timer_done)
    );

    always_comb begin
        st_d      = st_q;
        en_new    = wr_en ? wr_data[B_EN] : st_q.en;
        abort     = wr_en && !wr_data[B_EN] && st_q.en;
        launch    = wr_en && wr_data[B_EN] && wr_data[B_GO] && !st_q.go;
        conv_done = timer_done && !abort;

        first_new = st_q.first;
        if (wr_en && wr_data[B_EN] && !st_q.en) first_new = 1'b1;
        if (conv_done)                          first_new = 1'b0;

        st_d.en       = en_new;
        st_d.first    = first_new;
        st_d.trig_vld = launch;

        if (wr_en) begin
            st_d.psc  = wr_data[PSC_LSB +: PSC_W];
            st_d.chan = wr_data[CHAN_LSB +: CHAN_W];
            if (wr_data[B_FLAG]) st_d.flag = 1'b0;
        end
        if (conv_done) st_d.flag = 1'b1;

        if (launch) begin
            st_d.go       = 1'b1;
            st_d.div      = wr_data[PSC_LSB +: PSC_W];
            st_d.long_sel = first_new;
            st_d.trig_ch  = wr_data[CHAN_LSB +: CHAN_W];
        end else if (abort || conv_done) begin
            st_d.go = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data    = {st_q.chan, st_q.psc, st_q.flag, st_q.go, st_q.en};
    assign trig_valid = st_q.trig_vld;
    assign trig_chan  = st_q.trig_ch;
    assign irq        = st_q.flag;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [CHAN_LSB+CHAN_W-1:0] wr_data,
    input logic [CHAN_LSB+CHAN_W-1:0] rd_data,
    input logic                       trig_valid,
    input logic [CHAN_W-1:0]          trig_chan,
    input logic                       irq,
    input logic                       conv_done
);
    logic off_wr;
    assign off_wr = wr_en && !wr_data[B_EN];

    AST_GO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_GO] && !off_wr && !conv_done) |=> rd_data[B_GO]); // R1

    AST_TRIG_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> $rose(rd_data[B_GO])); // R2

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |=> !trig_valid); // R2

    AST_OFF_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[B_EN] && !(wr_en && wr_data[B_EN])) |=> !rd_data[B_GO]); // R3

    AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !off_wr) |=> (!rd_data[B_GO] && irq)); // R7

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_GO] && off_wr && !wr_data[B_FLAG]) |=> (!rd_data[B_GO] && irq == $past(irq))); // R8

    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_GO] && !trig_valid) |-> $stable(trig_chan)); // R10
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CHAN_W(CHAN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .trig_valid (trig_valid),
    .trig_chan  (trig_chan),
    .irq        (irq),
    .conv_done  (conv_done)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW  = 4;
    localparam int DW  = CW + 6;
    localparam int LF  = 25;
    localparam int LN  = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          trig_valid;
    logic [CW-1:0] trig_chan;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done_flag = 0;

    adc_seq_ctrl #(.CHAN_W(CW), .FIRST_LEN(LF), .NORMAL_LEN(LN)) u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .trig_valid(trig_valid), .trig_chan(trig_chan), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // behavioural reference model
    int m_en, m_go, m_first, m_flag, m_psc, m_chan, m_tv, m_tc, m_rem;

    function automatic int period(input int s);
        return 1 << ((s == 0) ? 1 : s);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_go = 0; m_first = 0; m_flag = 0; m_psc = 0;
            m_chan = 0; m_tv = 0; m_tc = 0; m_rem = 0;
        end else begin
            bit off, fin, start;
            off   = wr_en && !wr_data[0];
            fin   = (m_go != 0) && m_rem == 1 && !off;
            start = wr_en && wr_data[0] && wr_data[1] && (m_go == 0);
            if (wr_en && wr_data[0] && m_en == 0) m_first = 1;
            if (fin) m_first = 0;
            if (wr_en && wr_data[2]) m_flag = 0;
            if (fin) m_flag = 1;
            m_tv = start;
            if (start) begin
                m_go  = 1;
                m_rem = (m_first != 0 ? LF : LN) * period(int'(wr_data[5:3]));
                m_tc  = int'(wr_data[DW-1:6]);
            end else if (m_go != 0) begin
                if (off) m_go = 0;
                else begin
                    m_rem--;
                    if (m_rem == 0) m_go = 0;
                end
            end
            if (wr_en) begin
                m_en   = wr_data[0];
                m_psc  = int'(wr_data[5:3]);
                m_chan = int'(wr_data[DW-1:6]);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // compare against the model every cycle, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk("R1", int'(rd_data[1]), m_go, "start bit");
            chk("R9", int'(irq), m_flag, "irq");
            chk("R9", int'(rd_data[2]), m_flag, "flag bit");
            chk("R2", int'(trig_valid), m_tv, "trig_valid");
            chk("R10", int'(trig_chan), m_tc, "trig_chan");
            chk("R10", int'(rd_data), m_chan * 64 + m_psc * 8 + m_flag * 4 + m_go * 2 + m_en,
                "rd_data");
        end
    end

    function automatic logic [DW-1:0] word(input bit en, input bit go, input bit fl,
                                          input int psc, input int ch);
        return {CW'(ch), 3'(psc), fl, go, en};
    endfunction

    task automatic wr(input logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // launch and measure edges from start edge to the flag
    task automatic measure(input int psc, input int ch, input int exp, input string req);
        int t0;
        wr(word(1, 1, 0, psc, ch));
        t0 = cyc;
        chk("R2", int'(trig_valid), 1, "trigger pulse after start");
        chk("R2", int'(trig_chan), ch, "trigger channel");
        while (!irq) @(negedge clk);
        chk(req, cyc - t0, exp, "conversion length");
        chk("R7", int'(rd_data[1]), 0, "start bit after completion");
    endtask

    task automatic finish_up;
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        finish_up();
    end

    initial begin
        int t0;
        @(negedge clk); @(negedge clk);
        // R11 reset state
        chk("R11", int'(rd_data), 0, "rd_data in reset");
        chk("R11", int'(irq) + int'(trig_valid), 0, "outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", int'(rd_data), 0, "rd_data after reset");

        // R3 start with enable low
        wr(word(0, 1, 0, 2, 7));
        chk("R3", int'(rd_data[1]), 0, "start ignored when disabled");
        chk("R3", int'(trig_valid), 0, "no trigger when disabled");
        idle(40);
        chk("R3", int'(irq), 0, "no flag when disabled");

        // R5 + R4: first conversion, select 0 acts as 1
        wr(word(1, 0, 0, 0, 5));
        measure(0, 5, LF * 2, "R5");
        chk("R7", int'(irq), 1, "irq set at completion");

        // R9 flag stickiness
        wr(word(1, 0, 0, 0, 5));
        chk("R9", int'(irq), 1, "flag kept on write of 0");
        wr(word(1, 0, 1, 0, 5));
        chk("R9", int'(irq), 0, "flag cleared on write of 1");

        // R6 + R1 + R10: normal conversion with disturbing writes
        wr(word(1, 1, 0, 2, 3));
        t0 = cyc;
        chk("R2", int'(trig_chan), 3, "trigger channel 3");
        idle(5);
        wr(word(1, 0, 0, 2, 3));
        chk("R1", int'(rd_data[1]), 1, "start not cleared by zero write");
        wr(word(1, 1, 0, 0, 9));
        chk("R10", int'(trig_chan), 3, "channel held during conversion");
        while (!irq) @(negedge clk);
        chk("R6", cyc - t0, LN * 4, "normal length, divide 4");
        chk("R10", int'(trig_chan), 3, "channel after conversion");
        wr(word(1, 0, 1, 1, 0));

        // R4: select 1 equals select 0 period
        measure(1, 6, LN * 2, "R4");
        wr(word(1, 0, 1, 1, 0));

        // R8 abort
        wr(word(1, 1, 0, 1, 2));
        idle(10);
        wr(word(0, 0, 0, 1, 2));
        chk("R8", int'(rd_data[1]), 0, "abort clears start");
        idle(200);
        chk("R8", int'(irq), 0, "no flag after abort");

        // R5 again after re-enable, then R6 at divide 128
        wr(word(1, 0, 0, 3, 0));
        measure(3, 12, LF * 8, "R5");
        wr(word(1, 0, 1, 7, 0));
        measure(7, 15, LN * 128, "R6");
        idle(3);
        finish_up();
    end
endmodule